// File: doc/BRIEF.md
# Carry-less polynomial multiplier

This block is an execution-unit extension for a 32-bit RISC core. It multiplies two 32-bit polynomials whose coefficients are bits in GF(2). There are no carries and no modular reduction: each partial product is the multiplicand shifted by the position of a set multiplier bit, and the partial products are combined with XOR. Software uses the 64-bit product, delivered as a high word and a low word, as the building block for binary-field arithmetic.

A single-cycle `start` pulse captures both source operands. The unit then reports completion with a one-cycle `done` pulse, and the result words keep their value until the next accepted start. The parameter `IMPL` selects one of two implementations:

- The iterative variant reuses one shifter and one XOR. It handles one multiplier bit per clock and holds `busy` high while it runs.
- The parallel variant builds all partial products at once and registers the product in the cycle after the start.

Both variants give the same product for the same operands.

Top module: `clmul_unit`

## Requirements
- R1: When `done` is high, `{res_hi, res_lo}` equals the XOR over every i where `opb[i]` is 1 of `opa` shifted left by i. The result is 64 bits wide, with `res_lo` holding bits 31..0 and `res_hi` holding bits 63..32.
- R2: Bit 63 of the product (`res_hi[31]`) is always 0.
- R3: In the iterative variant, a start accepted while idle raises `busy` on the next cycle. `busy` stays high for exactly 32 cycles. `done` is high for one cycle, in the cycle right after the last busy cycle.
- R4: In the parallel variant, `busy` is never high and `done` is high in the cycle after each cycle in which `start` is high. This also holds for back-to-back starts.
- R5: In the iterative variant, a `start` that arrives while `busy` is high is ignored. The run in progress finishes at its normal time, with the product of its own operands.
- R6: If either operand is zero, the product is zero.
- R7: While the unit is idle and no start arrives, `res_hi` and `res_lo` hold the last product.
- R8: While `rst_n` is low, `busy`, `done`, `res_hi` and `res_lo` are all 0.
- R9: For the same operands, both variants give the same product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Capture operands and begin a multiply |
| opa | input | 32 | Multiplicand polynomial |
| opb | input | 32 | Multiplier polynomial |
| busy | output | 1 | Multiply in progress (iterative variant only) |
| done | output | 1 | One-cycle pulse: the result is valid |
| res_hi | output | 32 | Product bits 63..32 |
| res_lo | output | 32 | Product bits 31..0 |

## Verification
The iterative variant can go wrong in two ways:
- A slip in its step counter moves the falling edge of `busy` and the `done` pulse away from the 32nd cycle. The cycle-by-cycle model sees this within one clock of the expected end.
- A fault in the shift or XOR path changes the product itself. This appears as a result mismatch when `done` arrives, and again as a difference against the parallel variant fed the same operands.

An operand register overwritten by a start during a run shows up as a wrong product at the end of that run. A product register that does not hold shows up on the first idle cycle after it changes.

// File: rtl/clmul_pkg.sv
// Package: shared width and variant selector for the carry-less multiplier.
// Assumes: the word width is shared by both source operands.
package clmul_pkg;

    localparam int unsigned WORD_W = 32;

    // Implementation choice for the multiply datapath.
    typedef enum logic {
        IMPL_ITER = 1'b0,
        IMPL_PAR  = 1'b1
    } clmul_impl_e;

endpackage

// File: rtl/clmul_iter_core.sv
// Module: iterative carry-less multiplier.
// Handles one multiplier bit per clock with a shared shifter and XOR,
// so a run takes W cycles.
// Assumes: start is ignored while busy, and the product register is only
// meaningful once done has pulsed.
module clmul_iter_core #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] prod
);

    localparam int unsigned PW = 2 * W;
    localparam int unsigned CW = $clog2(W) + 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    logic [PW-1:0] mcand;
    logic [W-1:0]  mplier;
    logic [PW-1:0] acc;
    logic [CW-1:0] step;

    // Sequencer: load the operands on start, then run one shift-and-XOR step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            step   <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                acc    <= acc ^ (mplier[0] ? mcand : '0);
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                step   <= step + 1'b1;
                if (step == LAST_STEP) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end else if (start) begin
                mcand  <= {{W{1'b0}}, a};
                mplier <= b;
                acc    <= '0;
                step   <= '0;
                busy   <= 1'b1;
            end
        end
    end

    assign prod = acc;

endmodule

// File: rtl/clmul_par_core.sv
// Module: parallel carry-less multiplier.
// Forms all W partial products at once, reduces them with an XOR tree,
// and registers the product in the cycle after start.
// Assumes: a start may arrive on any cycle, and the unit is never busy.
module clmul_par_core #(
    parameter int unsigned W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] prod
);

    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] pp [W];
    logic [PW-1:0] sum_c;

    // One gated, shifted copy of the multiplicand per multiplier bit.
    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = b[i] ? ({{W{1'b0}}, a} << i) : '0;
    end

    // Carry-free sum of all partial products.
    always_comb begin
        sum_c = '0;
        for (int i = 0; i < W; i++) begin
            sum_c = sum_c ^ pp[i];
        end
    end

    // Product register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod <= '0;
            done <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                prod <= sum_c;
            end
        end
    end

    assign busy = 1'b0;

endmodule

// File: rtl/clmul_unit.sv
// Module: top of the carry-less polynomial multiplier.
// Picks the datapath variant with IMPL and splits the 2W-bit product
// into a high word and a low word.
// Assumes: a synchronous active-low reset, and a one-cycle start pulse.
module clmul_unit
    import clmul_pkg::*;
#(
    parameter int unsigned W    = WORD_W,
    parameter clmul_impl_e IMPL = IMPL_ITER
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo
);

    logic [2*W-1:0] prod;

    // Instantiate the variant that IMPL selects.
    if (IMPL == IMPL_ITER) begin : g_iter
        clmul_iter_core #(.W(W)) u_core (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start),
            .a     (opa),
            .b     (opb),
            .busy  (busy),
            .done  (done),
            .prod  (prod)
        );
    end else begin : g_par
        clmul_par_core #(.W(W)) u_core (
            .clk   (clk),
            .rst_n (rst_n),
            .start (start),
            .a     (opa),
            .b     (opb),
            .busy  (busy),
            .done  (done),
            .prod  (prod)
        );
    end

    assign res_hi = prod[2*W-1:W];
    assign res_lo = prod[W-1:0];

endmodule

// File: rtl/clmul_checks.sv
// Module: protocol checker for clmul_unit, attached with a bind statement.
// Assumes: the checker parameters match the bound instance.
module clmul_checks #(
    parameter int unsigned W       = 32,
    parameter bit          IS_ITER = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] res_hi,
    input logic [W-1:0] res_lo
);

    // R2: the top product bit can never be set.
    a_r2_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        res_hi[W-1] == 1'b0);

    // R7: results hold while idle with no start.
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_hi) && $stable(res_lo)));

    // R3/R4: done only while not busy.
    a_r3_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    if (IS_ITER) begin : g_iter
        logic [15:0] busy_len;

        // Count consecutive busy cycles so the run length can be checked.
        always_ff @(posedge clk) begin
            if (!rst_n)    busy_len <= '0;
            else if (busy) busy_len <= busy_len + 1'b1;
            else           busy_len <= '0;
        end

        // R3: an accepted start raises busy.
        a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
            (start && !busy) |=> busy);

        // R3: the run lasts exactly W cycles.
        a_r3_run_length: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy) |-> (busy_len == 16'(W)));

        // R3: busy never lasts longer than W cycles.
        a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
            busy_len <= 16'(W));

        // R3: done follows a busy cycle and lasts one cycle.
        a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> $past(busy));
        a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> !done);
    end else begin : g_par
        // R4: the parallel unit never reports busy.
        a_r4_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
            !busy);

        // R4: done comes exactly one cycle after each start.
        a_r4_start_done: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> done);
        a_r4_done_source: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> $past(start));
    end

endmodule

bind clmul_unit clmul_checks #(
    .W       (W),
    .IS_ITER (IMPL == clmul_pkg::IMPL_ITER)
) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .res_hi (res_hi),
    .res_lo (res_lo)
);

// File: tb/test_clmul_unit.sv
`timescale 1ns/1ps
module test_clmul_unit;
    import clmul_pkg::*;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_i = 1'b0;
    logic         st_p = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;

    logic         busy_i, done_i, busy_p, done_p;
    logic [W-1:0] hi_i, lo_i, hi_p, lo_p;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    clmul_unit #(.W(W), .IMPL(IMPL_ITER)) i_clmul_unit (
        .clk(clk), .rst_n(rst_n), .start(st_i), .opa(a), .opb(b),
        .busy(busy_i), .done(done_i), .res_hi(hi_i), .res_lo(lo_i));

    clmul_unit #(.W(W), .IMPL(IMPL_PAR)) i_clmul_unit_par (
        .clk(clk), .rst_n(rst_n), .start(st_p), .opa(a), .opb(b),
        .busy(busy_p), .done(done_p), .res_hi(hi_p), .res_lo(lo_p));

    // Behavioural carry-less product.
    function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        logic [63:0] p = '0;
        for (int i = 0; i < 32; i++)
            if (y[i]) p = p ^ (64'(x) << i);
        return p;
    endfunction

    // Cycle-level reference state.
    logic        m_busy = 0, m_done = 0, p_done = 0;
    logic [63:0] m_prod = '0, m_pend = '0, p_prod = '0;
    int          m_rem = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_prod <= '0; m_rem <= 0;
            p_done <= 0; p_prod <= '0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                m_rem <= m_rem - 1;
                if (m_rem == 1) begin
                    m_busy <= 0; m_done <= 1; m_prod <= m_pend;
                end
            end else if (st_i) begin
                m_busy <= 1; m_rem <= 32; m_pend <= ref_mul(a, b);
            end
            p_done <= st_p;
            if (st_p) p_prod <= ref_mul(a, b);
        end
    end

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare both instances against the model on every clock.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 busy", 64'(busy_i), 64'(m_busy));
            chk("R3 done", 64'(done_i), 64'(m_done));
            if (!m_busy) chk(m_done ? "R1 iter" : "R7 iter", {hi_i, lo_i}, m_prod);
            chk("R4 busy", 64'(busy_p), 64'(0));
            chk("R4 done", 64'(done_p), 64'(p_done));
            chk(p_done ? "R1 par" : "R7 par", {hi_p, lo_p}, p_prod);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic wait_done_i();
        bit seen = 0;
        for (int n = 0; n < 40 && !seen; n++) begin
            @(negedge clk);
            if (done_i) seen = 1;
        end
        if (!seen) chk("R3 timeout", 64'(0), 64'(1));
    endtask

    // One multiply on both variants, then explicit result checks.
    task automatic do_op(input logic [31:0] x, input logic [31:0] y, input string tag);
        @(posedge clk); #1;
        a = x; b = y; st_i = 1; st_p = 1;
        @(posedge clk); #1;
        st_i = 0; st_p = 0;
        wait_done_i();
        chk({tag, " R1"}, {hi_i, lo_i}, ref_mul(x, y));
        chk("R9 variants agree", {hi_i, lo_i}, {hi_p, lo_p});
        chk("R2 top bit", 64'(hi_i[31]), 64'(0));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state of both variants.
        chk("R8 iter", {62'(0), busy_i, done_i}, 64'(0));
        chk("R8 iter res", {hi_i, lo_i}, 64'(0));
        chk("R8 par", {62'(0), busy_p, done_p}, 64'(0));
        chk("R8 par res", {hi_p, lo_p}, 64'(0));
        @(posedge clk); #1;
        rst_n = 1;

        // Corner operands.
        do_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, "ones");
        do_op(32'h8000_0000, 32'h8000_0000, "msb");
        do_op(32'h0000_0001, 32'h1234_5678, "unit");
        do_op(32'h0000_0003, 32'h0000_0003, "small");
        do_op(32'h0000_0000, 32'hDEAD_BEEF, "zero a");
        chk("R6 zero a", {hi_i, lo_i}, 64'(0));
        do_op(32'hCAFE_F00D, 32'h0000_0000, "zero b");
        chk("R6 zero b", {hi_p, lo_p}, 64'(0));

        // R5: a start during a run is ignored.
        @(posedge clk); #1;
        a = 32'h1357_9BDF; b = 32'h0F0F_0F0F; st_i = 1;
        @(posedge clk); #1;
        st_i = 0;
        repeat (5) @(posedge clk);
        #1; a = 32'hFFFF_0000; b = 32'h00FF_FF00; st_i = 1;
        @(posedge clk); #1;
        st_i = 0;
        wait_done_i();
        chk("R5 start ignored", {hi_i, lo_i}, ref_mul(32'h1357_9BDF, 32'h0F0F_0F0F));

        // R7: idle hold over several cycles.
        repeat (6) @(negedge clk);
        chk("R7 held", {hi_i, lo_i}, ref_mul(32'h1357_9BDF, 32'h0F0F_0F0F));

        // R4: back-to-back starts on the parallel variant.
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            a = $urandom; b = $urandom; st_p = 1;
        end
        @(posedge clk); #1;
        st_p = 0;
        @(negedge clk);
        chk("R4 back-to-back", {hi_p, lo_p}, ref_mul(a, b));

        // Random operands on both variants.
        for (int k = 0; k < 40; k++) begin
            do_op($urandom, $urandom, "random");
        end

        repeat (4) @(posedge clk);
        report();
    end

endmodule